// File: doc/BRIEF.md
# Retransmit Setup Sequencer for a FIFO Read Port

This block sits on the read-clock side of a FIFO and lets a consumer read, a second time, data it has already read. A retransmit request (`rtx_n` sampled low on a read-clock edge) is honoured only if the read and write enables were both inactive on that edge and on the edge before it. When a request is honoured, the block starts a short setup phase of fixed length. It pulses a read-pointer reset so that the pointer returns to the first array location. For the whole phase it overrides the read-status flag to its "nothing to read" level.

The override level depends on the read mode captured on the accepting edge. In standard mode the empty flag is held low, and every word after setup, the first one included, needs a read strobe. In fall-through mode the ready flag is held high. In the last setup cycle the block asks the output register to load the first word, so that the word is on the outputs when the override drops and no read strobe is needed for it. Read strobes that arrive during setup are blocked. The RAM and the pointers themselves sit outside the block.

Top module: `rtx_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `ptr_rst`, `flag_ovr`, `flag_lvl`, `out_load` and `rd_go` are all 0 when `ren_n` is high.
- R2: A request is accepted on a rising edge where `rtx_n` is low and was high on the previous edge, `ren_n` and `wen_n` are high on that edge and on the previous edge, and no setup is in progress. `ptr_rst` is then 1 for exactly the one cycle that follows the accepting edge.
- R3: A request made while `ren_n` or `wen_n` is low, on the sampling edge or on the edge before it, is ignored: `ptr_rst` and `flag_ovr` stay 0.
- R4: `flag_ovr` is 1 for exactly SETUP_CYCLES cycles (default 3). These cycles start in the same cycle as the `ptr_rst` pulse.
- R5: While `flag_ovr` is 1, `flag_lvl` is 0 if `fwft` was 0 on the accepting edge (empty forced low) and 1 if it was 1 (ready forced high). Changes to `fwft` during setup do not alter it.
- R6: In fall-through mode `out_load` is 1 only in the last setup cycle. In standard mode it stays 0.
- R7: `rd_go` is 1 exactly when `ren_n` is low and no setup is in progress. After setup no read happens unless `ren_n` is low.
- R8: A request that arrives during setup neither restarts nor lengthens it.
- R9: Holding `rtx_n` low across the end of setup does not start a second setup. A new request needs `rtx_n` to return high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtx_n | input | 1 | Retransmit request, active low |
| ren_n | input | 1 | Read enable, active low |
| wen_n | input | 1 | Write enable, active low |
| fwft | input | 1 | Read mode: 0 standard, 1 fall-through |
| ptr_rst | output | 1 | One-cycle read-pointer reset to the first location |
| flag_ovr | output | 1 | Read-status flag override active (setup in progress) |
| flag_lvl | output | 1 | Level to force on the read-status flag while overridden |
| out_load | output | 1 | Load the first word into the output register |
| rd_go | output | 1 | Qualified read strobe to the read pointer |

## Verification
The bench issues requests with a read or write enable active on the sampling edge or on the edge before it. A qualifier that checks only the current edge would then start a setup phase that should never have begun. It issues a second request and holds read strobes low during setup. A design that re-arms or fails to gate would stretch the override or advance the pointer while it is being reset. It changes the mode bit mid-setup and holds the request low past the end of setup. These catch a level or load that follows the live pin, and a level-sensitive trigger that keeps restarting. Standard and fall-through sequences are compared cycle by cycle so that an off-by-one setup length, or a load in the wrong cycle or mode, shows up.

// File: rtl/rtx_pkg.sv
`timescale 1ns/1ps
package rtx_pkg;

  typedef enum logic [0:0] {
    MODE_STD  = 1'b0,
    MODE_FALL = 1'b1
  } rd_mode_e;

  typedef enum logic [0:0] {
    PH_IDLE  = 1'b0,
    PH_SETUP = 1'b1
  } rtx_phase_e;

  // Level the read-status flag is held at during setup:
  // empty low in standard mode, ready high in fall-through mode.
  function automatic logic hold_level(input rd_mode_e m);
    return (m == MODE_FALL);
  endfunction

  // A fall-through port needs the first word preloaded.
  function automatic logic needs_preload(input rd_mode_e m);
    return (m == MODE_FALL);
  endfunction

endpackage

// File: rtl/rtx_req_qual.sv
`timescale 1ns/1ps
module rtx_req_qual #(
  parameter int IDLE_HIST = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rtx_n,
  input  logic ren_n,
  input  logic wen_n,
  input  logic busy,
  output logic accept
);

  logic                 idle_now;
  logic                 rtx_prev;
  logic [IDLE_HIST-1:0] idle_hist;

  assign idle_now = ren_n & wen_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtx_prev <= 1'b1;
    else        rtx_prev <= rtx_n;
  end

  generate
    if (IDLE_HIST == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_hist <= '0;
        else        idle_hist <= idle_now;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_hist <= '0;
        else        idle_hist <= {idle_hist[IDLE_HIST-2:0], idle_now};
      end
    end
  endgenerate

  // fresh low on the request, enables quiet now and on the recorded past edges
  assign accept = ~rtx_n & rtx_prev & idle_now & (&idle_hist) & ~busy;

endmodule

// File: rtl/rtx_seq.sv
`timescale 1ns/1ps
module rtx_seq
  import rtx_pkg::*;
#(
  parameter int SETUP_CYCLES = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  rd_mode_e mode_in,
  output logic     busy,
  output logic     last,
  output logic     ptr_rst,
  output rd_mode_e mode_q
);

  localparam int CW = $clog2(SETUP_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(SETUP_CYCLES);
  localparam logic [CW-1:0] ONE      = CW'(1);

  rtx_phase_e    phase;
  logic [CW-1:0] remain;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - ONE;
  endfunction

  function automatic logic final_cycle(input logic [CW-1:0] c);
    return (c == ONE);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      remain  <= '0;
      ptr_rst <= 1'b0;
      mode_q  <= MODE_STD;
    end else begin
      ptr_rst <= accept;
      if (accept) begin
        phase  <= PH_SETUP;
        remain <= LOAD_VAL;
        mode_q <= mode_in;
      end else if (phase == PH_SETUP) begin
        remain <= step_down(remain);
        if (final_cycle(remain)) phase <= PH_IDLE;
      end
    end
  end

  assign busy = (phase == PH_SETUP);
  assign last = busy & final_cycle(remain);

endmodule

// File: rtl/rtx_outmap.sv
`timescale 1ns/1ps
module rtx_outmap
  import rtx_pkg::*;
(
  input  logic     busy,
  input  logic     last,
  input  rd_mode_e mode_q,
  input  logic     ren_n,
  output logic     flag_ovr,
  output logic     flag_lvl,
  output logic     out_load,
  output logic     rd_go
);

  always_comb begin
    flag_ovr = busy;
    flag_lvl = busy & hold_level(mode_q);
    out_load = last & needs_preload(mode_q);
    rd_go    = ~ren_n & ~busy;
  end

endmodule

// File: rtl/rtx_ctrl.sv
`timescale 1ns/1ps
module rtx_ctrl
  import rtx_pkg::*;
#(
  parameter int SETUP_CYCLES = 3,
  parameter int IDLE_HIST    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rtx_n,
  input  logic ren_n,
  input  logic wen_n,
  input  logic fwft,
  output logic ptr_rst,
  output logic flag_ovr,
  output logic flag_lvl,
  output logic out_load,
  output logic rd_go
);

  // internal events, named for the checker
  logic     req_ok;
  logic     setup_busy;
  logic     setup_last;
  rd_mode_e mode_held;

  rtx_req_qual #(.IDLE_HIST(IDLE_HIST)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .rtx_n  (rtx_n),
    .ren_n  (ren_n),
    .wen_n  (wen_n),
    .busy   (setup_busy),
    .accept (req_ok)
  );

  rtx_seq #(.SETUP_CYCLES(SETUP_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (req_ok),
    .mode_in (rd_mode_e'(fwft)),
    .busy    (setup_busy),
    .last    (setup_last),
    .ptr_rst (ptr_rst),
    .mode_q  (mode_held)
  );

  rtx_outmap u_map (
    .busy     (setup_busy),
    .last     (setup_last),
    .mode_q   (mode_held),
    .ren_n    (ren_n),
    .flag_ovr (flag_ovr),
    .flag_lvl (flag_lvl),
    .out_load (out_load),
    .rd_go    (rd_go)
  );

endmodule

// File: rtl/rtx_ctrl_chk.sv
`timescale 1ns/1ps
module rtx_ctrl_chk #(
  parameter int SETUP_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic rtx_n,
  input logic ren_n,
  input logic wen_n,
  input logic accept,
  input logic busy,
  input logic ptr_rst,
  input logic flag_ovr,
  input logic flag_lvl,
  input logic out_load,
  input logic rd_go
);

  logic [7:0] ovr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovr_run <= '0;
    else if (flag_ovr) ovr_run <= ovr_run + 8'd1;
    else               ovr_run <= '0;
  end

  p_ptr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> !ptr_rst);

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ptr_rst && flag_ovr));

  p_ignore_busy_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtx_n && (!ren_n || !wen_n)) |-> !accept);

  p_ovr_with_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovr) |-> ptr_rst);

  p_ovr_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_ovr) |-> (ovr_run == 8'(SETUP_CYCLES)));

  p_lvl_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovr && $past(flag_ovr) && !ptr_rst) |-> $stable(flag_lvl));

  p_load_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_load |-> (flag_ovr && flag_lvl));

  p_load_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_load |=> !flag_ovr);

  p_no_read_in_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovr |-> !rd_go);

  p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

endmodule

bind rtx_ctrl rtx_ctrl_chk #(.SETUP_CYCLES(SETUP_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rtx_n    (rtx_n),
  .ren_n    (ren_n),
  .wen_n    (wen_n),
  .accept   (req_ok),
  .busy     (setup_busy),
  .ptr_rst  (ptr_rst),
  .flag_ovr (flag_ovr),
  .flag_lvl (flag_lvl),
  .out_load (out_load),
  .rd_go    (rd_go)
);

// File: tb/rtx_ctrl_test.sv
`timescale 1ns/1ps
module rtx_ctrl_test;

  logic clk = 1'b0;
  logic rst_n, rtx_n, ren_n, wen_n, fwft;
  logic ptr_rst, flag_ovr, flag_lvl, out_load, rd_go;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  rtx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rtx_n(rtx_n), .ren_n(ren_n), .wen_n(wen_n),
    .fwft(fwft), .ptr_rst(ptr_rst), .flag_ovr(flag_ovr), .flag_lvl(flag_lvl),
    .out_load(out_load), .rd_go(rd_go)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rtx_n = 1'b1; ren_n = 1'b1; wen_n = 1'b1;
    end
  endtask

  // request sampled on the next edge; returns in setup cycle 1
  task automatic fire();
    @(negedge clk); rtx_n = 1'b0;
    @(negedge clk); rtx_n = 1'b1;
    #1;
  endtask

  task automatic t_std();
    idle(2); fwft = 1'b0;
    fire();
    chk("R2 std ptr_rst cycle1", ptr_rst, 1'b1);
    chk("R4 std ovr cycle1", flag_ovr, 1'b1);
    chk("R5 std level", flag_lvl, 1'b0);
    @(negedge clk); #1;
    chk("R2 std ptr_rst single pulse", ptr_rst, 1'b0);
    chk("R4 std ovr cycle2", flag_ovr, 1'b1);
    @(negedge clk); #1;
    chk("R4 std ovr cycle3", flag_ovr, 1'b1);
    chk("R6 std no load", out_load, 1'b0);
    @(negedge clk); #1;
    chk("R4 std ovr released", flag_ovr, 1'b0);
    chk("R7 std no read without ren", rd_go, 1'b0);
    ren_n = 1'b0; #1;
    chk("R7 std first word needs ren", rd_go, 1'b1);
    ren_n = 1'b1; #1;
  endtask

  task automatic t_fwft();
    idle(2); fwft = 1'b1;
    fire();
    chk("R5 fall level", flag_lvl, 1'b1);
    chk("R6 fall no early load", out_load, 1'b0);
    @(negedge clk); fwft = 1'b0; #1;
    chk("R5 level held after mode pin change", flag_lvl, 1'b1);
    chk("R6 fall no load cycle2", out_load, 1'b0);
    @(negedge clk); #1;
    chk("R6 fall load last cycle", out_load, 1'b1);
    chk("R4 fall ovr cycle3", flag_ovr, 1'b1);
    @(negedge clk); #1;
    chk("R4 fall ovr released", flag_ovr, 1'b0);
    chk("R6 fall load dropped", out_load, 1'b0);
    chk("R7 fall no read strobe", rd_go, 1'b0);
  endtask

  task automatic t_bad_ren();
    idle(2);
    @(negedge clk); ren_n = 1'b0;
    @(negedge clk); ren_n = 1'b1; rtx_n = 1'b0;
    @(negedge clk); rtx_n = 1'b1; #1;
    chk("R3 ren prior edge ptr_rst", ptr_rst, 1'b0);
    chk("R3 ren prior edge ovr", flag_ovr, 1'b0);
    idle(2);
    @(negedge clk); ren_n = 1'b0; rtx_n = 1'b0;
    @(negedge clk); ren_n = 1'b1; rtx_n = 1'b1; #1;
    chk("R3 ren same edge ovr", flag_ovr, 1'b0);
  endtask

  task automatic t_bad_wen();
    idle(2);
    @(negedge clk); wen_n = 1'b0; rtx_n = 1'b0;
    @(negedge clk); wen_n = 1'b1; rtx_n = 1'b1; #1;
    chk("R3 wen same edge ptr_rst", ptr_rst, 1'b0);
    chk("R3 wen same edge ovr", flag_ovr, 1'b0);
    idle(2);
    @(negedge clk); wen_n = 1'b0;
    @(negedge clk); wen_n = 1'b1; rtx_n = 1'b0;
    @(negedge clk); rtx_n = 1'b1; #1;
    chk("R3 wen prior edge ovr", flag_ovr, 1'b0);
  endtask

  task automatic t_read_in_setup();
    idle(2); fwft = 1'b0;
    fire();
    ren_n = 1'b0; #1;
    chk("R7 read blocked cycle1", rd_go, 1'b0);
    @(negedge clk); #1;
    chk("R7 read blocked cycle2", rd_go, 1'b0);
    @(negedge clk); #1;
    chk("R7 read blocked cycle3", rd_go, 1'b0);
    chk("R4 ren does not abort setup", flag_ovr, 1'b1);
    @(negedge clk); #1;
    chk("R7 read passes after setup", rd_go, 1'b1);
    ren_n = 1'b1;
  endtask

  task automatic t_rtx_in_setup();
    idle(2);
    fire();
    @(negedge clk); rtx_n = 1'b0;
    @(negedge clk); rtx_n = 1'b1; #1;
    chk("R8 no second pointer reset", ptr_rst, 1'b0);
    chk("R8 ovr still cycle3", flag_ovr, 1'b1);
    @(negedge clk); #1;
    chk("R8 setup not lengthened", flag_ovr, 1'b0);
    @(negedge clk); #1;
    chk("R8 no late restart", ptr_rst, 1'b0);
  endtask

  task automatic t_hold_rtx();
    idle(2);
    @(negedge clk); rtx_n = 1'b0;
    @(negedge clk); #1;
    chk("R9 held request accepted once", ptr_rst, 1'b1);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); #1;
    chk("R9 ovr ends with request held", flag_ovr, 1'b0);
    @(negedge clk); #1;
    chk("R9 no restart ptr_rst", ptr_rst, 1'b0);
    chk("R9 no restart ovr", flag_ovr, 1'b0);
    rtx_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; rtx_n = 1'b1; ren_n = 1'b1; wen_n = 1'b1; fwft = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ptr_rst", ptr_rst, 1'b0);
    chk("R1 reset ovr", flag_ovr, 1'b0);
    chk("R1 reset lvl", flag_lvl, 1'b0);
    chk("R1 reset load", out_load, 1'b0);
    chk("R1 reset rd_go", rd_go, 1'b0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 after reset ovr", flag_ovr, 1'b0);
    t_std();
    t_fwft();
    t_bad_ren();
    t_bad_wen();
    t_read_in_setup();
    t_rtx_in_setup();
    t_hold_rtx();
    idle(2);
    summary();
    $finish;
  end

endmodule